// File: doc/BRIEF.md
# Instruction Exception Entry Sequencer

This block takes exception requests raised by the instruction decoder of a small 32-bit processor and carries out the entry into the handler. A trap instruction arrives as a one-cycle pulse with an 8-bit vector number. An undefined opcode arrives as its own pulse, together with a flag that says whether that opcode sits in the delay slot of a delayed-branch or PC-writing instruction. An undefined opcode in a delay slot is an illegal-slot exception. One anywhere else is a general illegal exception.

After it accepts a request, the sequencer stalls fetch. It pushes the status register and then the return address onto the stack through a single-word memory port that uses request and acknowledge. It reads the handler address from a vector table and hands the new PC and stack pointer to the core in one load cycle. The jump is not delayed, so nothing after the faulting instruction executes before the handler.

Top module: `exc_entry_seq`

## Requirements
- R1: `exc_kind` reads 2'b00 while idle. It holds the class of the accepted exception while busy: 2'b01 trap, 2'b10 general illegal (undefined opcode with `in_slot` low), 2'b11 illegal slot (undefined opcode with `in_slot` high). `in_slot` has no effect on a trap.
- R2: If `trap_req` and `undef_req` pulse in the same cycle, the undefined-opcode exception is taken.
- R3: The first memory access is a write of `sr_in` to `sp_in - 4`. The second is a write of the return address to `sp_in - 8`.
- R4: The return address is `cur_pc + 2` for a trap, `branch_pc` for an illegal-slot exception, and `cur_pc` for a general illegal exception.
- R5: The third access is a read from `vbr + 4*n`. Here n is `trap_vec` for a trap, 4 for a general illegal exception and 6 for an illegal-slot exception.
- R6: After the read is acknowledged, `pc_load` and `sp_load` are high for exactly one cycle. In that cycle `pc_out` equals the word that was read and `sp_out` equals `sp_in - 8`.
- R7: A memory access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack` is seen. Each accepted exception makes exactly three accesses.
- R8: `busy` rises in the cycle after the request. It stays high up to and including the load cycle and is low in the cycle after that.
- R9: A request that arrives while `busy` is high, including during the load cycle, is ignored. It causes no access and leaves the current sequence unchanged.
- R10: In reset, `busy`, `mem_req`, `pc_load`, `sp_load` and `exc_kind` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_req | input | 1 | Trap instruction decoded (one-cycle pulse) |
| trap_vec | input | 8 | Vector number carried by the trap |
| undef_req | input | 1 | Undefined opcode decoded (one-cycle pulse) |
| in_slot | input | 1 | Current instruction is in a delay slot |
| cur_pc | input | 32 | Address of the current instruction |
| branch_pc | input | 32 | Address of the branch that owns the delay slot |
| sr_in | input | 32 | Current status register |
| sp_in | input | 32 | Current stack pointer |
| vbr | input | 32 | Vector table base address |
| busy | output | 1 | Fetch stall, high during the entry sequence |
| exc_kind | output | 2 | Class of the exception being entered |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| pc_load | output | 1 | Load `pc_out` into the PC |
| pc_out | output | 32 | Handler start address |
| sp_load | output | 1 | Load `sp_out` into the stack pointer |
| sp_out | output | 32 | Stack pointer after both pushes |

## Verification
Two things can fall in the same cycle. The first is a trap pulse together with an undefined-opcode pulse. The bench drives both at once and expects the illegal-opcode class, the fixed vector and the illegal-opcode return address. The second is a fresh request landing in the load cycle, or in the middle of a stalled access. The bench pulses a trap at exactly those points, with the memory acknowledge delayed to make the stall. It then checks that exactly three accesses were logged, that the final PC and SP belong to the first exception, and that `busy` stays low afterwards.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN     = 32,
  parameter int VW       = 8,
  parameter int ILEN     = 2,
  parameter int VEC_GEN  = 4,
  parameter int VEC_SLOT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_req,
  input  logic [VW-1:0]   trap_vec,
  input  logic            undef_req,
  input  logic            in_slot,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] branch_pc,
  input  logic [XLEN-1:0] sr_in,
  input  logic [XLEN-1:0] sp_in,
  input  logic [XLEN-1:0] vbr,
  output logic            busy,
  output logic [1:0]      exc_kind,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            pc_load,
  output logic [XLEN-1:0] pc_out,
  output logic            sp_load,
  output logic [XLEN-1:0] sp_out
);
  localparam int WB = XLEN / 8;
  localparam int SH = $clog2(WB);

  typedef enum logic [2:0] {S_IDLE, S_PUSH_SR, S_PUSH_PC, S_FETCH, S_LOAD} st_t;

  st_t             st;
  logic [1:0]      kind;
  logic [VW-1:0]   vec_r;
  logic [XLEN-1:0] ret_r, sr_r, sp_r, pc_r;

  wire accept = (st == S_IDLE) && (trap_req || undef_req);
  wire pushing = (st == S_PUSH_SR) || (st == S_PUSH_PC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      kind  <= 2'b00;
      vec_r <= '0;
      ret_r <= '0;
      sr_r  <= '0;
      sp_r  <= '0;
      pc_r  <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          sr_r <= sr_in;
          sp_r <= sp_in;
          st   <= S_PUSH_SR;
          if (undef_req) begin
            kind  <= in_slot ? 2'b11 : 2'b10;
            ret_r <= in_slot ? branch_pc : cur_pc;
            vec_r <= in_slot ? VW'(VEC_SLOT) : VW'(VEC_GEN);
          end else begin
            kind  <= 2'b01;
            ret_r <= cur_pc + XLEN'(ILEN);
            vec_r <= trap_vec;
          end
        end
        S_PUSH_SR: if (mem_ack) begin
          sp_r <= sp_r - XLEN'(WB);
          st   <= S_PUSH_PC;
        end
        S_PUSH_PC: if (mem_ack) begin
          sp_r <= sp_r - XLEN'(WB);
          st   <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          pc_r <= mem_rdata;
          st   <= S_LOAD;
        end
        default: begin
          kind <= 2'b00;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign exc_kind  = kind;
  assign mem_req   = pushing || (st == S_FETCH);
  assign mem_we    = pushing;
  assign mem_addr  = pushing ? sp_r - XLEN'(WB) : vbr + (XLEN'(vec_r) << SH);
  assign mem_wdata = (st == S_PUSH_SR) ? sr_r : ret_r;
  assign pc_load   = (st == S_LOAD);
  assign sp_load   = (st == S_LOAD);
  assign pc_out    = pc_r;
  assign sp_out    = sp_r;

  a_r1_kind_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (exc_kind != 2'b00));

  a_r3_sr_pushed_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req && mem_we && mem_wdata == $past(sr_in));

  a_r5_general_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && exc_kind == 2'b10) |-> mem_addr == vbr + XLEN'(VEC_GEN * WB));

  a_r6_load_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(mem_req && !mem_we && mem_ack) && sp_load);

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r8_idle_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  a_r9_request_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (trap_req || undef_req)) |=> (!busy || $stable(exc_kind)));
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam logic [31:0] VBR = 32'h0001_0000;
  localparam logic [31:0] KEY = 32'h1234_5678;
  localparam int NV = 6;
  localparam logic [2:0]  V_CTL  [NV] = '{3'b100, 3'b010, 3'b011, 3'b110, 3'b101, 3'b100};
  localparam logic [7:0]  V_VEC  [NV] = '{8'h20, 8'h00, 8'h00, 8'h33, 8'hFF, 8'h00};
  localparam logic [31:0] V_PC   [NV] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000, 32'h5000, 32'h6000};
  localparam int          V_WAIT [NV] = '{0, 0, 1, 2, 3, 1};
  localparam bit          V_INJ  [NV] = '{0, 1, 0, 0, 1, 0};

  logic clk = 0, rst_n = 0;
  logic trap_req = 0, undef_req = 0, in_slot = 0, mem_ack = 0;
  logic [7:0]  trap_vec = '0;
  logic [31:0] cur_pc = '0, branch_pc = '0, sr_in = '0, sp_in = '0, vbr = VBR, mem_rdata = '0;
  logic busy, mem_req, mem_we, pc_load, sp_load;
  logic [1:0] exc_kind;
  logic [31:0] mem_addr, mem_wdata, pc_out, sp_out;

  int checks = 0, failures = 0, ack_wait = 0, cnt = 0, tx_n = 0, hold_bad = 0;
  logic [31:0] tx_addr [8];
  logic [31:0] tx_data [8];
  logic        tx_we   [8];
  logic [31:0] first_addr;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_vec(trap_vec),
    .undef_req(undef_req), .in_slot(in_slot), .cur_pc(cur_pc), .branch_pc(branch_pc),
    .sr_in(sr_in), .sp_in(sp_in), .vbr(vbr), .busy(busy), .exc_kind(exc_kind),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pc_load(pc_load), .pc_out(pc_out),
    .sp_load(sp_load), .sp_out(sp_out));

  always #10 clk = ~clk;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (mem_req) begin
        if (cnt == 0) first_addr = mem_addr;
        else if (mem_addr !== first_addr) hold_bad++;
        if (cnt >= ack_wait) begin
          mem_ack = 1;
          mem_rdata = ~mem_addr ^ KEY;
          if (tx_n < 8) begin
            tx_addr[tx_n] = mem_addr; tx_data[tx_n] = mem_wdata; tx_we[tx_n] = mem_we;
          end
          tx_n++;
          cnt = 0;
        end else begin
          mem_ack = 0; mem_rdata = '0; cnt++;
        end
      end else begin
        mem_ack = 0; cnt = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic run_exc(bit t, bit u, bit s, logic [7:0] v, logic [31:0] pc, int w, bit inj);
    logic [1:0]  kind = u ? (s ? 2'b11 : 2'b10) : 2'b01;
    logic [31:0] ret  = u ? (s ? pc - 2 : pc) : pc + 2;
    logic [31:0] vn   = u ? (s ? 32'd6 : 32'd4) : {24'd0, v};
    logic [31:0] va   = VBR + vn * 4;
    logic [31:0] sr   = pc ^ 32'h0000_00F0;
    logic [31:0] sp   = 32'h8000_0000 - pc;
    int n = 0;
    @(negedge clk);
    tx_n = 0; hold_bad = 0; ack_wait = w;
    trap_req = t; undef_req = u; in_slot = s; trap_vec = v;
    cur_pc = pc; branch_pc = pc - 2; sr_in = sr; sp_in = sp;
    @(negedge clk);
    trap_req = 0; undef_req = 0; in_slot = 0;
    #2;
    chk("R8 busy after request", 32'(busy), 1);
    chk("R1 R2 exception class", 32'(exc_kind), 32'(kind));
    while (!pc_load && n < 60) begin
      @(negedge clk);
      trap_req = 0;
      #2;
      if (inj && n == 1) trap_req = 1;
      n++;
    end
    trap_req = 0;
    chk("R6 pc_out", pc_out, ~va ^ KEY);
    chk("R6 sp_out", sp_out, sp - 8);
    chk("R6 sp_load", 32'(sp_load), 1);
    chk("R8 busy in load", 32'(busy), 1);
    chk("R7 access count", 32'(tx_n), 3);
    chk("R7 held until ack", 32'(hold_bad), 0);
    chk("R3 sr push addr", tx_addr[0], sp - 4);
    chk("R3 sr push data", tx_data[0], sr);
    chk("R3 sr push write", 32'(tx_we[0]), 1);
    chk("R3 pc push addr", tx_addr[1], sp - 8);
    chk("R4 return address", tx_data[1], ret);
    chk("R5 vector read addr", tx_addr[2], va);
    chk("R5 vector is read", 32'(tx_we[2]), 0);
    if (inj) begin
      trap_req = 1;
      @(posedge clk); #1;
      trap_req = 0;
    end
    @(negedge clk); #2;
    chk("R8 idle after load", 32'(busy), 0);
    chk("R1 idle class", 32'(exc_kind), 0);
    if (inj) begin
      repeat (3) @(negedge clk);
      #2;
      chk("R9 ignored stays idle", 32'(busy), 0);
      chk("R9 no extra access", 32'(tx_n), 3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R10 busy in reset", 32'(busy), 0);
    chk("R10 mem_req in reset", 32'(mem_req), 0);
    chk("R10 load in reset", 32'({pc_load, sp_load}), 0);
    chk("R10 class in reset", 32'(exc_kind), 0);
    rst_n = 1;
    @(negedge clk); #2;
    chk("R10 idle after reset", 32'({busy, mem_req, pc_load}), 0);
    for (int i = 0; i < NV; i++)
      run_exc(V_CTL[i][2], V_CTL[i][1], V_CTL[i][0], V_VEC[i], V_PC[i], V_WAIT[i], V_INJ[i]);
    run_exc(1'b0, 1'b1, 1'b1, 8'h00, 32'h7000, 4, 1'b1);
    run_exc(1'b1, 1'b1, 1'b1, 8'h44, 32'h8000, 0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule